// File: doc/BRIEF.md
# Interleaved Time-Slot System Bus Multiplexer

This block lets several independent framer channels share one serial system bus. Each channel supplies a byte-wide buffer for 32 time slots of PCM data and a matching buffer of per-channel signaling. The block sends them out as two serial lines, one for PCM and one for signaling, plus a frame sync. Every time-slot number is repeated once for each bus member before the next slot number starts. A shared counter walks through the frame. One bit is emitted per bus clock.

Two bus rates are supported, and the choice is independent of the line rate. In the 4.096 MHz arrangement two members (A and B) share the bus. In the 8.192 MHz arrangement four members (A to D) share it. The data lines and the sync line can each be launched on either edge of the bus clock. A member that is switched off transmits the all-ones idle code in its slots.

Top module: `tsi_bus_mux`

## Requirements
- R1: With `mode_i`=0 the frame has two members and is 512 bits long. With `mode_i`=1 it has four members and is 1024 bits long. The next frame sync follows exactly one frame length after the previous one.
- R2: Within a frame, slots go out in ascending slot number. Inside each slot number, members go out in the order A, B, C, D, each byte MSB first. The frame therefore opens with TS0 of A and closes with TS31 of the last member.
- R3: The byte for member m (A=0 … D=3) and slot s is read from bits `[(m*32+s)*8 +: 8]` of the flat input vector. Bit 7 of that byte is sent first.
- R4: The signaling line uses the same member, slot and bit order as the PCM line. Each signaling bit is output in the same bus clock as the PCM bit of the same member, slot and bit position.
- R5: `fsync_o` is high for exactly one bus clock per frame, coinciding with the first bit of TS0 of member A.
- R6: With `data_neg_i`=0, `pcm_o` and `sig_o` change just after the rising clock edge. With `data_neg_i`=1 they change just after the falling edge, half a clock later and with the same bit sequence.
- R7: With `sync_neg_i`=0, `fsync_o` changes after the rising edge. With `sync_neg_i`=1 it changes after the falling edge.
- R8: While `member_en_i[m]` is 0, every bit of member m's slots on both `pcm_o` and `sig_o` is 1.
- R9: With `mode_i`=0, enable bits 3:2 and the buffer contents of members C and D have no effect on any output.
- R10: While `rst_n` is low, `fsync_o` is 0 and `pcm_o` and `sig_o` are 1. The first rising edge with `rst_n` high launches the sync pulse and the first bit of TS0 of member A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0: two members (4.096 MHz), 1: four members (8.192 MHz) |
| data_neg_i | input | 1 | Data launch edge: 0 rising, 1 falling |
| sync_neg_i | input | 1 | Sync launch edge: 0 rising, 1 falling |
| member_en_i | input | 4 | Per-member enable; a disabled member sends idle ones |
| pcm_slots_i | input | 1024 | PCM bytes of all members and slots, flat |
| sig_slots_i | input | 1024 | Signaling bytes of all members and slots, flat |
| pcm_o | output | 1 | Serial PCM bus line |
| sig_o | output | 1 | Serial signaling bus line |
| fsync_o | output | 1 | Frame sync pulse |

## Verification
The bench builds the block with its default parameters: 32 slots, up to four members and 8-bit slots. This makes both the 512-bit two-member frame and the 1024-bit four-member frame reachable, including the frame wrap between the last member's TS31 and TS0 of A. The outputs are sampled twice in every bus clock, once after each edge. This separates rising-edge launch from falling-edge launch for each line, including the mixed case where data and sync use different edges. The enable masks cover an idle member in each mode, and in two-member mode they set enable bits for the absent members to confirm those bits are ignored.

// File: rtl/tsi_pkg.sv
// Shared definitions for the interleaved time-slot bus multiplexer.
// Assumes slot count, member count and slot width are powers of two.
package tsi_pkg;

    // Default geometry of one bus frame
    localparam int TSI_SLOTS       = 32;
    localparam int TSI_MAX_MEMBERS = 4;
    localparam int TSI_BYTE_W      = 8;

    // Bus arrangement selected by the mode input
    typedef enum logic {
        BUS_PAIR = 1'b0,   // two members, half-length frame
        BUS_QUAD = 1'b1    // all members, full-length frame
    } bus_mode_e;

    // Output lanes that share one launch structure
    localparam int LANE_PCM  = 0;
    localparam int LANE_SIG  = 1;
    localparam int LANE_SYNC = 2;
    localparam int LANES     = 3;

endpackage

// File: rtl/tsi_frame_counter.sv
// Frame position counter. Counts bus clocks through one frame and splits the
// position into bit, member and slot fields for the active bus arrangement.
// Assumes power-of-two geometry and MAX_MEMBERS >= 4, so the pair arrangement
// uses one less member bit than the quad arrangement.
module tsi_frame_counter
    import tsi_pkg::*;
#(
    parameter int SLOTS       = TSI_SLOTS,
    parameter int MAX_MEMBERS = TSI_MAX_MEMBERS,
    parameter int BYTE_W      = TSI_BYTE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           mode_i,
    output logic [$clog2(BYTE_W)+$clog2(MAX_MEMBERS)+$clog2(SLOTS)-1:0] cnt_o,
    output logic [$clog2(BYTE_W)-1:0]      bit_o,
    output logic [$clog2(MAX_MEMBERS)-1:0] mem_o,
    output logic [$clog2(SLOTS)-1:0]       slot_o,
    output logic                           start_o
);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int MEM_W  = $clog2(MAX_MEMBERS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = BIT_W + MEM_W + SLOT_W;
    localparam int FULL   = SLOTS * MAX_MEMBERS * BYTE_W;

    bus_mode_e        mode;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;

    assign mode = bus_mode_e'(mode_i);

    // Last position of the frame depends on the bus arrangement
    always_comb begin
        if (mode == BUS_QUAD) wrap = (cnt_q == CNT_W'(FULL - 1));
        else                  wrap = (cnt_q >= CNT_W'(FULL / 2 - 1));
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    end

    // Frame position register, restarts at TS0 of member A after reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    // Field split: bit is least significant, then member, then slot
    always_comb begin
        bit_o = cnt_q[BIT_W-1:0];
        if (mode == BUS_QUAD) begin
            mem_o  = cnt_q[BIT_W +: MEM_W];
            slot_o = cnt_q[BIT_W+MEM_W +: SLOT_W];
        end else begin
            mem_o  = {1'b0, cnt_q[BIT_W +: MEM_W-1]};
            slot_o = cnt_q[BIT_W+MEM_W-1 +: SLOT_W];
        end
    end

    assign cnt_o   = cnt_q;
    assign start_o = (cnt_q == '0);

    // R5
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/tsi_slot_pick.sv
// Bit selector for one serial lane. Picks the bit of the addressed member and
// slot out of the flat byte buffer, MSB first, or idle ones for a disabled
// member. Purely combinational; the launch stage registers the result.
// Assumes the flat vector holds member-major, slot-minor bytes.
module tsi_slot_pick
    import tsi_pkg::*;
#(
    parameter int SLOTS       = TSI_SLOTS,
    parameter int MAX_MEMBERS = TSI_MAX_MEMBERS,
    parameter int BYTE_W      = TSI_BYTE_W
) (
    input  logic [SLOTS*MAX_MEMBERS*BYTE_W-1:0] slots_i,
    input  logic [MAX_MEMBERS-1:0]              member_en_i,
    input  logic [$clog2(MAX_MEMBERS)-1:0]      mem_i,
    input  logic [$clog2(SLOTS)-1:0]            slot_i,
    input  logic [$clog2(BYTE_W)-1:0]           bit_i,
    output logic                                bit_o
);
    localparam int IDX_W = $clog2(SLOTS * MAX_MEMBERS * BYTE_W);

    logic [IDX_W-1:0] idx;

    // Inverted bit count turns position 0 into the byte's MSB
    assign idx = {mem_i, slot_i, ~bit_i};

    // Idle code replaces the data of a switched-off member
    always_comb begin
        if (member_en_i[mem_i]) bit_o = slots_i[idx];
        else                    bit_o = 1'b1;
    end

endmodule

// File: rtl/tsi_edge_launch.sv
// Launch stage for one output lane. A rising-edge register captures the lane
// value; a falling-edge register copies it half a clock later. The edge
// select picks which of the two drives the pin. Both reset synchronously.
module tsi_edge_launch #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic neg_i,
    input  logic d_i,
    output logic rise_o,
    output logic out_o
);
    logic rise_q;
    logic fall_q;

    // Rising-edge launch register
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= RST_VAL;
        else        rise_q <= d_i;
    end

    // Falling-edge copy, delays the lane by half a clock
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= RST_VAL;
        else        fall_q <= rise_q;
    end

    assign rise_o = rise_q;
    assign out_o  = neg_i ? fall_q : rise_q;

    // R6
    half_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q == rise_q);

endmodule

// File: rtl/tsi_bus_mux.sv
// Interleaved time-slot bus multiplexer, top level. One frame counter drives
// a bit picker per data lane. Each data lane and the sync lane pass through
// an edge-selectable launch stage. Assumes the configuration inputs change
// only while reset is held.
module tsi_bus_mux
    import tsi_pkg::*;
#(
    parameter int SLOTS       = TSI_SLOTS,
    parameter int MAX_MEMBERS = TSI_MAX_MEMBERS,
    parameter int BYTE_W      = TSI_BYTE_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                mode_i,
    input  logic                                data_neg_i,
    input  logic                                sync_neg_i,
    input  logic [MAX_MEMBERS-1:0]              member_en_i,
    input  logic [SLOTS*MAX_MEMBERS*BYTE_W-1:0] pcm_slots_i,
    input  logic [SLOTS*MAX_MEMBERS*BYTE_W-1:0] sig_slots_i,
    output logic                                pcm_o,
    output logic                                sig_o,
    output logic                                fsync_o
);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int MEM_W  = $clog2(MAX_MEMBERS);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CNT_W  = BIT_W + MEM_W + SLOT_W;
    localparam int FLAT_W = SLOTS * MAX_MEMBERS * BYTE_W;
    localparam logic [LANES-1:0] LANE_RST = 3'b011;  // sync low, data idle high

    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_sel;
    logic [MEM_W-1:0]  mem_sel;
    logic [SLOT_W-1:0] slot_sel;
    logic              frame_start;

    logic [1:0][FLAT_W-1:0] lane_buf;
    logic [LANES-1:0]       lane_d;
    logic [LANES-1:0]       lane_neg;
    logic [LANES-1:0]       lane_rise;
    logic [LANES-1:0]       lane_out;

    tsi_frame_counter #(
        .SLOTS(SLOTS), .MAX_MEMBERS(MAX_MEMBERS), .BYTE_W(BYTE_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .cnt_o(cnt), .bit_o(bit_sel), .mem_o(mem_sel),
        .slot_o(slot_sel), .start_o(frame_start)
    );

    assign lane_buf[LANE_PCM] = pcm_slots_i;
    assign lane_buf[LANE_SIG] = sig_slots_i;

    // One bit picker per data lane, both addressed by the same counter
    for (genvar g = 0; g < 2; g++) begin : g_pick
        tsi_slot_pick #(
            .SLOTS(SLOTS), .MAX_MEMBERS(MAX_MEMBERS), .BYTE_W(BYTE_W)
        ) u_pick (
            .slots_i(lane_buf[g]), .member_en_i(member_en_i),
            .mem_i(mem_sel), .slot_i(slot_sel), .bit_i(bit_sel),
            .bit_o(lane_d[g])
        );
    end

    assign lane_d[LANE_SYNC]   = frame_start;
    assign lane_neg[LANE_PCM]  = data_neg_i;
    assign lane_neg[LANE_SIG]  = data_neg_i;
    assign lane_neg[LANE_SYNC] = sync_neg_i;

    // Identical launch stage on every lane keeps the lanes bit-aligned
    for (genvar g = 0; g < LANES; g++) begin : g_launch
        tsi_edge_launch #(.RST_VAL(LANE_RST[g])) u_launch (
            .clk(clk), .rst_n(rst_n), .neg_i(lane_neg[g]),
            .d_i(lane_d[g]), .rise_o(lane_rise[g]), .out_o(lane_out[g])
        );
    end

    assign pcm_o   = lane_out[LANE_PCM];
    assign sig_o   = lane_out[LANE_SIG];
    assign fsync_o = lane_out[LANE_SYNC];

    // R5
    sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_rise[LANE_SYNC] |-> (cnt == CNT_W'(1)));

    // R8
    idle_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !member_en_i[mem_sel] |=> (lane_rise[LANE_PCM] && lane_rise[LANE_SIG]));

    // R4
    lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!member_en_i[mem_sel] && $stable(data_neg_i)) |=> (pcm_o == sig_o));

endmodule

// File: tb/sim_tsi_bus_mux.sv
// Scoreboard bench: a driver task queues the expected bus items of whole
// frames, a monitor task pops them and compares them after both clock edges.
module sim_tsi_bus_mux;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode = 1'b0;
    logic cfg_dneg = 1'b0;
    logic cfg_sneg = 1'b0;
    logic [3:0] cfg_en = 4'hF;
    logic [1023:0] pcm_v = '0;
    logic [1023:0] sig_v = '0;
    logic pcm_o, sig_o, fsync_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed { logic sy; logic pc; logic sg; } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    tsi_bus_mux u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(cfg_mode),
        .data_neg_i(cfg_dneg), .sync_neg_i(cfg_sneg), .member_en_i(cfg_en),
        .pcm_slots_i(pcm_v), .sig_slots_i(sig_v),
        .pcm_o(pcm_o), .sig_o(sig_o), .fsync_o(fsync_o)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // R3: expected bit from member-major flat layout, MSB first; R8 idle ones
    function automatic logic exp_bit(input logic [1023:0] v, input int p);
        int nm = cfg_mode ? 4 : 2;
        int slot = p / (8 * nm);
        int mem = (p / 8) % nm;
        int b = 7 - (p % 8);
        if (!cfg_en[mem]) return 1'b1;
        return v[(mem * 32 + slot) * 8 + b];
    endfunction

    // Driver: queue expected items for whole frames (R1, R2, R4)
    task automatic push_frames(input int nfr);
        int len = cfg_mode ? 1024 : 512;
        for (int f = 0; f < nfr; f++)
            for (int p = 0; p < len; p++) begin
                item_t it;
                it.sy = (p == 0);
                it.pc = exp_bit(pcm_v, p);
                it.sg = exp_bit(sig_v, p);
                q.push_back(it);
            end
    endtask

    // Monitor: sample after falling edge (all lanes settled) and after rising edge
    task automatic run_mon(input string tag);
        int guard = 0;
        item_t cur, nxt;
        @(negedge clk); #1;
        while (fsync_o !== 1'b1 && guard < 3000) begin
            @(negedge clk); #1;
            guard++;
        end
        // R10: sync and TS0A bit 7 come from the first rising edge after release
        chk(guard == 1, 1'b1, "R10", {tag, " first sync position"});
        while (q.size() > 0) begin
            cur = q.pop_front();
            chk(pcm_o, cur.pc, "R2", {tag, " pcm"});
            chk(sig_o, cur.sg, "R4", {tag, " sig"});
            chk(fsync_o, cur.sy, "R5", {tag, " sync"});
            @(posedge clk); #1;
            if (q.size() > 0) begin
                nxt = q[0];
                chk(pcm_o, cfg_dneg ? cur.pc : nxt.pc, "R6", {tag, " pcm edge"});
                chk(sig_o, cfg_dneg ? cur.sg : nxt.sg, "R6", {tag, " sig edge"});
                chk(fsync_o, cfg_sneg ? cur.sy : nxt.sy, "R7", {tag, " sync edge"});
            end
            @(negedge clk); #1;
        end
        // R1: next sync exactly one frame length after the last queued frame
        chk(fsync_o, 1'b1, "R1", {tag, " frame length"});
    endtask

    task automatic run_phase(input logic md, input logic dn, input logic sn,
                             input logic [3:0] en, input int seed, input string tag);
        @(posedge clk); #1;
        rst_n = 1'b0;
        cfg_mode = md; cfg_dneg = dn; cfg_sneg = sn; cfg_en = en;
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 32; s++) begin
                pcm_v[(m * 32 + s) * 8 +: 8] = 8'(m * 67 + s * 13 + seed * 41);
                sig_v[(m * 32 + s) * 8 +: 8] = 8'(m * 29 + s * 71 + seed * 3 + 8'h33);
            end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(fsync_o, 1'b0, "R10", {tag, " reset sync"});
        chk(pcm_o, 1'b1, "R10", {tag, " reset pcm"});
        chk(sig_o, 1'b1, "R10", {tag, " reset sig"});
        @(posedge clk); #1;
        rst_n = 1'b1;
        q.delete();
        push_frames(2);
        run_mon(tag);
    endtask

    initial begin
        run_phase(1'b0, 1'b0, 1'b0, 4'b1111, 1, "pair rise");          // R1 R2
        run_phase(1'b1, 1'b1, 1'b1, 4'b1111, 2, "quad fall");          // R6 R7
        run_phase(1'b1, 1'b0, 1'b1, 4'b1011, 3, "quad mixed idleC");   // R7 R8
        run_phase(1'b0, 1'b1, 1'b0, 4'b1110, 4, "pair idleA r9_ign");  // R8 R9
        run_phase(1'b1, 1'b0, 1'b0, 4'b0111, 5, "quad idleD");         // R8
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule